// File: doc/BRIEF.md
# Multiplexed Local Bus Transaction Sequencer

This block converts one host read or write request at a time into a cycle on an external bus whose address and data share the same AD lines, for a single chip select. Each cycle begins with an address phase, in which the address is driven on AD and the address strobe is high. An idle gap of the same length follows. Then comes a data phase, in which the chip select and either the read or the write strobe are held low while data moves on AD. The host is acknowledged after the data phase.

A configuration word shapes every cycle. Its fields set the following:
- the address strobe width;
- the port width;
- byte or word address scaling;
- how two 8-bit wait counts give the read and write wait states;
- byte-lane reversal, enabled separately for reads and for writes;
- whether the device accepts writes only.

A read to a write-only device never reaches the bus. The same is true of a transfer with a reserved size code. Such a request ends with an error acknowledge, and an interrupt pulse is raised if interrupts are enabled.

Top module: `mbus_seq`

## Requirements
- R1: The address strobe `bus_ale` stays high for 1, 2, 3 or 4 clocks for `cfg_ale_len` codes 00, 01, 10 and 11. While it is high, `bus_ad_o` carries the bus address and `bus_ad_oe` is 1.
- R2: After `bus_ale` falls, `bus_cs_n` stays high for exactly as many clocks as `bus_ale` was high, and then falls.
- R3: In the data phase, `bus_cs_n` and the strobe for the direction (`bus_we_n` for writes, `bus_oe_n` for reads) are low for 1 + N clocks. N is set by `cfg_wait_mode` from `cfg_wait_lo` (L) and `cfg_wait_hi` (H):
  - 00: L for reads and writes.
  - 01: L for reads, H for writes.
  - 10: L for reads, {H,L} for writes.
  - 11: {H,L} for reads and writes.
- R4: Write data is right-aligned on `bus_ad_o` during the data phase. Bytes above the transfer width are zero. When `cfg_wr_swap`=1, the bytes are reversed within the transfer width (AB becomes BA, ABCD becomes DCBA).
- R5: Read data is taken from `bus_ad_i` in the last data-phase clock, masked to the transfer width, and reversed in the same way only when `cfg_rd_swap`=1. This is independent of `cfg_wr_swap`.
- R6: Size codes are 00 for 1 byte, 01 for 2 bytes, 11 for 4 bytes and 10 for reserved. The transfer width is the smaller of `req_size` and `cfg_port_size`. This means a 1-byte port never swaps.
- R7: When `cfg_wr_only`=1, a read produces no strobe on the bus. It is acknowledged with `ack_err`=1 and `rdata`=0, and `irq` pulses with the acknowledge only when `cfg_irq_en`=1. Writes to such a device run normally.
- R8: A reserved code (10) in either `cfg_port_size` or `req_size` ends the request the same way as R7, with no bus cycle.
- R9: The bus address is the byte address when `cfg_word_addr`=0 or the port is 1 byte wide. Otherwise it is the byte address shifted right by 1 for a 2-byte port, or by 2 for a 4-byte port.
- R10: The configuration and request fields are captured on the clock edge where the request is accepted. Changes made later do not affect the running cycle.
- R11: While in reset and after reset: `bus_ale`=0, `bus_cs_n`=`bus_oe_n`=`bus_we_n`=1, `bus_ad_oe`=0, `ack`=0 and `irq`=0.
- R12: `ack` is a one-clock pulse. The read and write strobes are never low together, are low only while `bus_cs_n` is low, and `bus_cs_n` is never low while `bus_ale` is high. A request still held high during `ack` starts a new cycle two clocks after `ack` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| ack | output | 1 | One-clock completion pulse |
| ack_err | output | 1 | Request terminated without bus cycle |
| rdata | output | 32 | Read data, valid with ack |
| irq | output | 1 | Error interrupt pulse |
| cfg_ale_len | input | 2 | Address strobe length code |
| cfg_port_size | input | 2 | Device port width code |
| cfg_word_addr | input | 1 | Word address scaling enable |
| cfg_wait_mode | input | 2 | Wait count selection mode |
| cfg_wait_lo | input | 8 | Low wait count L |
| cfg_wait_hi | input | 8 | High wait count H |
| cfg_rd_swap | input | 1 | Reverse bytes on reads |
| cfg_wr_swap | input | 1 | Reverse bytes on writes |
| cfg_wr_only | input | 1 | Device accepts writes only |
| cfg_irq_en | input | 1 | Enable error interrupt |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ad_o | output | 32 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Drive enable for AD lines |
| bus_ad_i | input | 32 | Shared address/data lines, sampled value |

## Verification
Two events can fall in the same cycle: the configuration inputs changing and a request being accepted. The bench moves the configuration one clock after acceptance, to a longer strobe and a longer wait. It then judges that the measured strobe, gap and data-phase lengths still match the values captured at acceptance. The acknowledge of one request can also coincide with the next request still being held high. The bench keeps `req` high through `ack` and checks that `ack` drops, that the bus is idle for one clock, and that the address strobe of the second cycle rises on the clock after that.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_RSVD = 2'b10;
  localparam logic [1:0] SZ_WORD = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ALE  = 3'd1,
    S_ISO  = 3'd2,
    S_DATA = 3'd3,
    S_ACK  = 3'd4
  } seq_state_e;

  // number of byte lanes used by a size code
  function automatic int unsigned size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 1;
      SZ_HALF: size_bytes = 2;
      default: size_bytes = 4;
    endcase
  endfunction

endpackage

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign last   = (cnt_q == '0);
  assign cnt_en = load || !last;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mbus_wait_sel.sv
module mbus_wait_sel #(
  parameter int WW = 8,
  localparam int CW = 2 * WW
) (
  input  logic [1:0]    mode,
  input  logic          is_write,
  input  logic [WW-1:0] wait_lo,
  input  logic [WW-1:0] wait_hi,
  output logic [CW-1:0] wait_cnt
);

  logic [CW-1:0] lo_ext;
  logic [CW-1:0] hi_ext;
  logic [CW-1:0] joined;

  assign lo_ext = CW'(wait_lo);
  assign hi_ext = CW'(wait_hi);
  assign joined = {wait_hi, wait_lo};

  always_comb begin
    unique case (mode)
      2'b00: wait_cnt = lo_ext;
      2'b01: wait_cnt = is_write ? hi_ext : lo_ext;
      2'b10: wait_cnt = is_write ? joined : lo_ext;
      default: wait_cnt = joined;
    endcase
  end

endmodule

// File: rtl/mbus_addr_map.sv
module mbus_addr_map
  import mbus_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] byte_addr,
  input  logic [1:0]    port_size,
  input  logic          word_mode,
  output logic [AW-1:0] bus_addr
);

  always_comb begin
    if (!word_mode || port_size == SZ_BYTE) bus_addr = byte_addr;
    else if (port_size == SZ_HALF)          bus_addr = byte_addr >> 1;
    else                                    bus_addr = byte_addr >> 2;
  end

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
  import mbus_pkg::*;
#(
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    size_code,
  input  logic          swap,
  output logic [DW-1:0] dout
);

  int unsigned nbytes;

  always_comb begin
    nbytes = size_bytes(size_code);
    dout   = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(nbytes)) begin
        if (swap) dout[8*i +: 8] = din[8*(int'(nbytes) - 1 - i) +: 8];
        else      dout[8*i +: 8] = din[8*i +: 8];
      end
    end
  end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic          ack_err,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic [1:0]    cfg_ale_len,
  input  logic [1:0]    cfg_port_size,
  input  logic          cfg_word_addr,
  input  logic [1:0]    cfg_wait_mode,
  input  logic [WW-1:0] cfg_wait_lo,
  input  logic [WW-1:0] cfg_wait_hi,
  input  logic          cfg_rd_swap,
  input  logic          cfg_wr_swap,
  input  logic          cfg_wr_only,
  input  logic          cfg_irq_en,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i
);

  localparam int CW = 2 * WW;
  localparam int NB = DW / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  seq_state_e    state_q, state_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          last;

  logic          we_q, err_q, rswap_q, irqen_q;
  logic [1:0]    ale_q, esz_q;
  logic [CW-1:0] wait_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] wdat_q, rdat_q;

  logic          accept;
  logic          blocked;
  logic [1:0]    esz;
  logic [CW-1:0] wsel;
  logic [AW-1:0] mapped;
  logic [DW-1:0] wlane, rlane;
  logic          rd_cap;

  // request decode
  assign esz     = (req_size < cfg_port_size) ? req_size : cfg_port_size;
  assign blocked = (req_size == SZ_RSVD) || (cfg_port_size == SZ_RSVD) ||
                   (!req_we && cfg_wr_only);
  assign accept  = (state_q == S_IDLE) && req;
  assign rd_cap  = (state_q == S_DATA) && last && !we_q;

  mbus_wait_sel #(.WW(WW)) i_wait_sel (
    .mode     (cfg_wait_mode),
    .is_write (req_we),
    .wait_lo  (cfg_wait_lo),
    .wait_hi  (cfg_wait_hi),
    .wait_cnt (wsel)
  );

  mbus_addr_map #(.AW(AW)) i_addr_map (
    .byte_addr (req_addr),
    .port_size (cfg_port_size),
    .word_mode (cfg_word_addr),
    .bus_addr  (mapped)
  );

  mbus_lane #(.NB(NB)) i_wr_lane (
    .din       (req_wdata),
    .size_code (esz),
    .swap      (cfg_wr_swap),
    .dout      (wlane)
  );

  mbus_lane #(.NB(NB)) i_rd_lane (
    .din       (bus_ad_i),
    .size_code (esz_q),
    .swap      (rswap_q),
    .dout      (rlane)
  );

  mbus_phase_ctr #(.CW(CW)) i_phase_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ld),
    .load_val (ld_val),
    .last     (last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (req) begin
          if (blocked) begin
            state_d = S_ACK;
          end else begin
            state_d = S_ALE;
            ld      = 1'b1;
            ld_val  = CW'(cfg_ale_len);
          end
        end
      end
      S_ALE: begin
        if (last) begin
          state_d = S_ISO;
          ld      = 1'b1;
          ld_val  = CW'(ale_q);
        end
      end
      S_ISO: begin
        if (last) begin
          state_d = S_DATA;
          ld      = 1'b1;
          ld_val  = wait_q;
        end
      end
      S_DATA: begin
        if (last) state_d = S_ACK;
      end
      S_ACK:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_IDLE;
    else            state_q <= state_d;
  end

  // transaction capture, enabled on accept
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      rswap_q <= 1'b0;
      irqen_q <= 1'b0;
      ale_q   <= '0;
      esz_q   <= '0;
      wait_q  <= '0;
      adr_q   <= '0;
      wdat_q  <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      err_q   <= blocked;
      rswap_q <= cfg_rd_swap;
      irqen_q <= cfg_irq_en;
      ale_q   <= cfg_ale_len;
      esz_q   <= esz;
      wait_q  <= wsel;
      adr_q   <= mapped;
      wdat_q  <= req_we ? wlane : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdat_q <= '0;
    else if (accept) rdat_q <= '0;
    else if (rd_cap) rdat_q <= rlane;
  end

  // outputs
  assign ack       = (state_q == S_ACK);
  assign ack_err   = ack && err_q;
  assign irq       = ack && err_q && irqen_q;
  assign rdata     = ack ? rdat_q : '0;

  assign bus_ale   = (state_q == S_ALE);
  assign bus_cs_n  = (state_q != S_DATA);
  assign bus_oe_n  = !((state_q == S_DATA) && !we_q);
  assign bus_we_n  = !((state_q == S_DATA) && we_q);
  assign bus_ad_oe = bus_ale || !bus_we_n;
  assign bus_ad_o  = bus_ale ? DW'(adr_q) : (!bus_we_n ? wdat_q : '0);

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ale,
  input logic bus_cs_n,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_ad_oe,
  input logic ack,
  input logic ack_err,
  input logic irq
);

  logic [2:0] ale_run;
  logic [2:0] iso_run;
  logic       ale_d;
  logic       cs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_run <= '0;
      iso_run <= '0;
      ale_d   <= 1'b0;
      cs_seen <= 1'b0;
    end else begin
      ale_d <= bus_ale;
      if (bus_ale && !ale_d)               ale_run <= 3'd1;
      else if (bus_ale && ale_run != 3'd7) ale_run <= ale_run + 3'd1;
      if (bus_ale)                          iso_run <= '0;
      else if (bus_cs_n && iso_run != 3'd7) iso_run <= iso_run + 3'd1;
      if (ack)            cs_seen <= 1'b0;
      else if (!bus_cs_n) cs_seen <= 1'b1;
    end
  end

  a_r1_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (ale_run >= 3'd1 && ale_run <= 3'd4));

  a_r2_iso_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> (iso_run == ale_run));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_ad_oe);

  a_r7_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_err) |-> !cs_seen);

  a_r7_ok_had_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_err) |-> cs_seen);

  a_r7_irq_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ack && ack_err));

  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  a_r12_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  a_r12_cs_not_ale: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !bus_ale);

endmodule

bind mbus_seq mbus_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ale   (bus_ale),
  .bus_cs_n  (bus_cs_n),
  .bus_oe_n  (bus_oe_n),
  .bus_we_n  (bus_we_n),
  .bus_ad_oe (bus_ad_oe),
  .ack       (ack),
  .ack_err   (ack_err),
  .irq       (irq)
);

// File: tb/test_mbus_seq.sv
`timescale 1ns/1ps
module test_mbus_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        ack, ack_err, irq;
  logic [31:0] rdata;
  logic [1:0]  cfg_ale_len, cfg_port_size, cfg_wait_mode;
  logic        cfg_word_addr, cfg_rd_swap, cfg_wr_swap, cfg_wr_only, cfg_irq_en;
  logic [7:0]  cfg_wait_lo, cfg_wait_hi;
  logic        bus_ale, bus_cs_n, bus_oe_n, bus_we_n, bus_ad_oe;
  logic [31:0] bus_ad_o, bus_ad_i;

  int n_chk = 0;
  int n_err = 0;

  int          m_ale, m_iso, m_data, m_we, m_oe;
  logic [31:0] m_addr, m_wdat, m_rdata;
  logic        m_err, m_irq, m_ack;

  always #2.5 clk = ~clk;

  mbus_seq i_mbus_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .ack_err(ack_err),
    .rdata(rdata), .irq(irq), .cfg_ale_len(cfg_ale_len),
    .cfg_port_size(cfg_port_size), .cfg_word_addr(cfg_word_addr),
    .cfg_wait_mode(cfg_wait_mode), .cfg_wait_lo(cfg_wait_lo),
    .cfg_wait_hi(cfg_wait_hi), .cfg_rd_swap(cfg_rd_swap),
    .cfg_wr_swap(cfg_wr_swap), .cfg_wr_only(cfg_wr_only),
    .cfg_irq_en(cfg_irq_en), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] ale, input logic [1:0] psz, input logic wa,
                         input logic [1:0] wm, input logic [7:0] lo, input logic [7:0] hi,
                         input logic rs, input logic ws, input logic wo, input logic ie);
    cfg_ale_len = ale; cfg_port_size = psz; cfg_word_addr = wa; cfg_wait_mode = wm;
    cfg_wait_lo = lo; cfg_wait_hi = hi; cfg_rd_swap = rs; cfg_wr_swap = ws;
    cfg_wr_only = wo; cfg_irq_en = ie;
  endtask

  // samples each negedge until ack, counting bus phases
  task automatic measure();
    m_ale = 0; m_iso = 0; m_data = 0; m_we = 0; m_oe = 0;
    m_addr = '0; m_wdat = '0; m_ack = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (ack) begin
        m_ack = 1'b1; m_err = ack_err; m_irq = irq; m_rdata = rdata;
        break;
      end
      if (bus_ale) begin
        m_ale++;
        if (bus_ad_oe) m_addr = bus_ad_o;
      end else if (!bus_cs_n) begin
        m_data++;
        if (!bus_we_n) begin m_we++; m_wdat = bus_ad_o; end
        if (!bus_oe_n) m_oe++;
      end else if (m_data == 0) begin
        m_iso++;
      end
    end
  endtask

  task automatic do_txn(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic hold);
    req = 1'b1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd;
    measure();
    if (!hold) req = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 ale", {31'd0, bus_ale}, 32'd0);
    check("R11 cs_n", {31'd0, bus_cs_n}, 32'd1);
    check("R11 oe_n/we_n", {30'd0, bus_oe_n, bus_we_n}, 32'd3);
    check("R11 ad_oe", {31'd0, bus_ad_oe}, 32'd0);
    check("R11 ack/irq", {30'd0, ack, irq}, 32'd0);
  endtask

  task automatic t_basic_write();
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd2, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b1, 32'h1000_0010, 2'b11, 32'h1122_3344, 1'b0);
    check("R1 ale len 00", m_ale, 1);
    check("R1 address", m_addr, 32'h1000_0010);
    check("R2 iso", m_iso, 1);
    check("R3 data mode00", m_data, 3);
    check("R3 we cycles", m_we, 3);
    check("R4 wdata no swap", m_wdat, 32'h1122_3344);
    check("R7 no err", {31'd0, m_err}, 32'd0);
  endtask

  task automatic t_long_ale_swap();
    set_cfg(2'b11, 2'b11, 1'b0, 2'b01, 8'd5, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    do_txn(1'b1, 32'h40, 2'b11, 32'h0102_0304, 1'b0);
    check("R1 ale len 11", m_ale, 4);
    check("R2 iso 4", m_iso, 4);
    check("R3 mode01 write uses hi", m_data, 2);
    check("R4 4-byte swap", m_wdat, 32'h0403_0201);
    @(negedge clk);
    bus_ad_i = 32'h5566_7788;
    do_txn(1'b0, 32'h44, 2'b11, 32'h0, 1'b0);
    check("R3 mode01 read uses lo", m_data, 6);
    check("R5 oe cycles", m_oe, 6);
    check("R5 read no swap with wr swap on", m_rdata, 32'h5566_7788);
  endtask

  task automatic t_narrow_read();
    set_cfg(2'b01, 2'b11, 1'b0, 2'b10, 8'd3, 8'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    bus_ad_i = 32'hAABB_CCDD;
    do_txn(1'b0, 32'h8, 2'b01, 32'h0, 1'b0);
    check("R1 ale len 01", m_ale, 2);
    check("R3 mode10 read", m_data, 4);
    check("R6 R5 2-byte read swap", m_rdata, 32'h0000_DDCC);
    @(negedge clk);
    do_txn(1'b1, 32'h8, 2'b01, 32'h1234_5678, 1'b0);
    check("R4 masked no swap", m_wdat, 32'h0000_5678);
  endtask

  task automatic t_byte_port();
    set_cfg(2'b00, 2'b00, 1'b1, 2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_txn(1'b1, 32'h203, 2'b11, 32'h1234_ABEF, 1'b0);
    check("R6 byte port no swap", m_wdat, 32'h0000_00EF);
    check("R9 byte port byte addr", m_addr, 32'h203);
    check("R3 zero wait", m_data, 1);
  endtask

  task automatic t_word_addr();
    set_cfg(2'b00, 2'b01, 1'b1, 2'b00, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    do_txn(1'b1, 32'h100, 2'b01, 32'h0000_BEEF, 1'b0);
    check("R9 2-byte word addr", m_addr, 32'h80);
    check("R4 2-byte swap", m_wdat, 32'h0000_EFBE);
    @(negedge clk);
    set_cfg(2'b00, 2'b11, 1'b1, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b0, 32'h100, 2'b11, 32'h0, 1'b0);
    check("R9 4-byte word addr", m_addr, 32'h40);
  endtask

  task automatic t_wait_modes();
    set_cfg(2'b00, 2'b11, 1'b0, 2'b10, 8'd2, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b1, 32'h0, 2'b11, 32'h1, 1'b0);
    check("R3 mode10 write 16-bit", m_data, 259);
    @(negedge clk);
    set_cfg(2'b00, 2'b11, 1'b0, 2'b11, 8'd0, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b0, 32'h0, 2'b11, 32'h0, 1'b0);
    check("R3 mode11 read 16-bit", m_data, 257);
    @(negedge clk);
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd0, 8'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b1, 32'h0, 2'b11, 32'h0, 1'b0);
    check("R3 mode00 hi ignored", m_data, 1);
  endtask

  task automatic t_write_only();
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd1, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    bus_ad_i = 32'hDEAD_BEEF;
    do_txn(1'b0, 32'h0, 2'b11, 32'h0, 1'b0);
    check("R7 ack", {31'd0, m_ack}, 32'd1);
    check("R7 err", {31'd0, m_err}, 32'd1);
    check("R7 irq enabled", {31'd0, m_irq}, 32'd1);
    check("R7 rdata zero", m_rdata, 32'h0);
    check("R7 no bus", m_ale + m_data, 0);
    @(negedge clk);
    cfg_irq_en = 1'b0;
    do_txn(1'b0, 32'h0, 2'b11, 32'h0, 1'b0);
    check("R7 irq disabled", {30'd0, m_err, m_irq}, 32'd2);
    @(negedge clk);
    do_txn(1'b1, 32'h0, 2'b11, 32'h5, 1'b0);
    check("R7 write allowed", m_data, 2);
    check("R7 write no err", {31'd0, m_err}, 32'd0);
  endtask

  task automatic t_reserved();
    set_cfg(2'b00, 2'b10, 1'b0, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    do_txn(1'b1, 32'h0, 2'b11, 32'h1, 1'b0);
    check("R8 reserved port err", {31'd0, m_err}, 32'd1);
    check("R8 reserved port no bus", m_ale + m_data, 0);
    @(negedge clk);
    cfg_port_size = 2'b11;
    do_txn(1'b0, 32'h0, 2'b10, 32'h0, 1'b0);
    check("R8 reserved size err", {30'd0, m_err, m_irq}, 32'd3);
  endtask

  task automatic t_cfg_change();
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    req = 1'b1; req_we = 1'b1; req_addr = 32'h0; req_size = 2'b11; req_wdata = 32'h9;
    @(negedge clk);
    check("R10 first ale cycle", {31'd0, bus_ale}, 32'd1);
    cfg_ale_len = 2'b11; cfg_wait_lo = 8'd7; cfg_wr_swap = 1'b1;
    measure();
    req = 1'b0;
    check("R10 ale not extended", m_ale, 0);
    check("R10 iso kept", m_iso, 1);
    check("R10 wait kept", m_data, 2);
    check("R10 data kept", m_wdat, 32'h9);
  endtask

  task automatic t_back_to_back();
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_txn(1'b1, 32'h0, 2'b11, 32'h1, 1'b1);
    check("R12 first ack", {31'd0, m_ack}, 32'd1);
    @(negedge clk);
    check("R12 ack one cycle", {30'd0, ack, bus_ale}, 32'd0);
    @(negedge clk);
    check("R12 next ale", {31'd0, bus_ale}, 32'd1);
    measure();
    req = 1'b0;
    check("R12 second done", {30'd0, m_ack, m_err}, 32'd2);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_size = 2'b11;
    req_addr = '0; req_wdata = '0; bus_ad_i = '0;
    set_cfg(2'b00, 2'b11, 1'b0, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_write();     @(negedge clk);
    t_long_ale_swap();   @(negedge clk);
    t_narrow_read();     @(negedge clk);
    t_byte_port();       @(negedge clk);
    t_word_addr();       @(negedge clk);
    t_wait_modes();      @(negedge clk);
    t_write_only();      @(negedge clk);
    t_reserved();        @(negedge clk);
    t_cfg_change();      @(negedge clk);
    t_back_to_back();    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule